// File: doc/BRIEF.md
# Synchronous Serial Expansion Port

This block is a single-target serial master that moves one byte at a time over a three-wire link: a serial clock it drives, a data line it drives and a data line it samples. A processor reaches it through three byte-wide registers: control, data and status. Writing a byte into the data register while the port is enabled and idle sends that byte. Setting the receive-go bit in the control register takes in one byte from the far side. Bits travel most-significant first in both directions.

The serial clock comes from a machine-cycle enable pulse (`mc_tick`) divided by 4, 8, 16 or 32, chosen by a two-bit rate field. A polarity bit sets the idle level of the serial clock. A phase bit chooses whether the leading or the trailing clock edge is the one that samples. When a transfer ends, a sticky done flag is set and drives the interrupt line. While a transfer is running, a data-register access or a control write is blocked. It leaves the register and the transfer untouched and sets one of two sticky error flags, which never raise the interrupt.

Top module: `serport_master`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00, and `sclk`, `sdo` and `irq` are all low.
- R2: Register map. Address 0 is control: bit0 enable, bit1 clock polarity, bit2 clock phase, bits4:3 rate, bit5 receive-go. Address 1 is data. Address 2 is status: bit0 done, bit1 write error, bit2 read error. A data write while enabled and idle sends the byte MSB first in exactly 16 `sclk` toggles. `sclk` idles at the polarity bit.
- R3: With phase 0, each bit is valid on `sdo` before the leading edge of its clock pulse, and `sdi` is sampled on the leading edge. With phase 1, `sdo` changes on the leading edge and `sdi` is sampled on the trailing edge.
- R4: `sclk` toggles every 2, 4, 8 or 16 `mc_tick` pulses for rate codes 0, 1, 2 and 3. Without `mc_tick` pulses a transfer makes no progress.
- R5: A control write with enable=1 and receive-go=1 starts a receive only if the port is idle and no unread received byte is held. Otherwise receive-go reads back 0 and no clock is produced. Reading the data register while idle releases the held byte.
- R6: A receive shifts in 8 bits MSB first. At completion the byte is readable from the data register and receive-go reads back 0.
- R7: Every completed transfer sets done. `irq` equals done. Writing 1 to status bit0 clears done.
- R8: During a send, a data read or write, or a control write, is ignored and sets the write-error bit. The register is unchanged and the byte on the line is unaffected.
- R9: During a receive, the same accesses are ignored and set the read-error bit. The received byte is unaffected.
- R10: The error bits do not drive `irq`. Each stays set until 1 is written to its own status bit, and clearing done leaves it set.
- R11: With enable=0, a data write and a receive-go write produce no clock and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle enable pulse |
| bus_sel | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data read has side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest situations to reach are register accesses that land in the middle of a transfer. Such an access must leave a half-shifted byte intact and set only the error flag that matches the direction. The bench starts slow transfers at rate 3, so it has room to fire blocked data writes, data reads and control writes mid-flight. It then has its own slave model confirm that the full original byte still crossed the link. A receive-go written while a received byte is still unread is reached by deliberately skipping the data read after a receive.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int unsigned RATE_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_TX   = 2'd1,
    XF_RX   = 2'd2
  } xfer_e;

  // Packed so that en lands in bit0 and rx_go in bit5.
  typedef struct packed {
    logic              rx_go;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              en;
  } ctrl_t;

  // Ticks per serial clock half period.
  function automatic int unsigned half_ticks(input logic [RATE_W-1:0] rate,
                                             input int unsigned base_shift);
    return 32'd1 << (base_shift + int'(rate));
  endfunction
endpackage

// File: rtl/serport_clkgen.sv
module serport_clkgen import serport_pkg::*; #(
  parameter int unsigned EDGES      = 16,
  parameter int unsigned BASE_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              edge_stb,
  output logic              leading,
  output logic              last,
  output logic              phase
);
  localparam int unsigned CNT_W = BASE_SHIFT + (1 << RATE_W);
  localparam int unsigned EC_W  = $clog2(EDGES);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] top_cnt;
  logic [EC_W-1:0]  ecnt_q;
  logic             phase_q;

  assign top_cnt  = CNT_W'(half_ticks(rate, BASE_SHIFT) - 1);
  assign edge_stb = run && tick && (div_q == top_cnt);
  assign leading  = ~ecnt_q[0];
  assign last     = (ecnt_q == EC_W'(EDGES - 1));
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (start) begin
      div_q   <= '0;
      ecnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (run && tick) begin
      if (edge_stb) begin
        div_q   <= '0;
        phase_q <= ~phase_q;
        ecnt_q  <= ecnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R2: an even number of toggles brings the clock home once the transfer stops
  p_phase_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !phase_q);
  // R4: the divider never passes the selected half period
  p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_q <= top_cnt));
endmodule

// File: rtl/serport_shift.sv
module serport_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          edge_stb,
  input  logic          leading,
  input  logic          cpha,
  input  logic          sdi,
  output logic [DW-1:0] shreg,
  output logic          sdo
);
  logic [DW-1:0] sh_q;
  logic          samp_q;
  logic          sdo_q;
  logic          sample_edge;

  assign sample_edge = leading ^ cpha;
  assign shreg       = sh_q;
  assign sdo         = sdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (load) begin
      sh_q   <= load_data;
      sdo_q  <= load_data[DW-1];
      samp_q <= 1'b0;
    end else if (edge_stb) begin
      if (sample_edge) begin
        if (!cpha) samp_q <= sdi;
        else       sh_q   <= {sh_q[DW-2:0], sdi};
      end else begin
        if (!cpha) begin
          sh_q  <= {sh_q[DW-2:0], samp_q};
          sdo_q <= sh_q[DW-2];
        end else begin
          sdo_q <= sh_q[DW-1];
        end
      end
    end
  end

  // R3: the output only moves on a launch edge or a load
  p_sdo_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(edge_stb && !sample_edge)) |=> $stable(sdo_q));
endmodule

// File: rtl/serport_master.sv
module serport_master import serport_pkg::*; #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BASE_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q, wctrl;
  xfer_e mode_q;
  logic  full_q, done_q, werr_q, rerr_q;

  logic busy, data_wr, data_rd, ctrl_wr, stat_wr, blocked;
  logic tx_start, rx_start, finish;
  logic edge_stb, leading, last, phase;
  logic [DATA_W-1:0] shreg;

  assign busy    = (mode_q != XF_IDLE);
  assign data_wr = bus_wr && (bus_sel == REG_DATA);
  assign data_rd = bus_rd && (bus_sel == REG_DATA);
  assign ctrl_wr = bus_wr && (bus_sel == REG_CTRL);
  assign stat_wr = bus_wr && (bus_sel == REG_STAT);
  assign blocked = busy && (data_wr || data_rd || ctrl_wr);
  assign wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  assign tx_start = data_wr && !busy && ctrl_q.en;
  assign rx_start = ctrl_wr && !busy && wctrl.rx_go && wctrl.en && !full_q;
  assign finish   = edge_stb && last;

  serport_clkgen #(.EDGES(EDGES), .BASE_SHIFT(BASE_SHIFT)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .run(busy),
    .start(tx_start || rx_start), .rate(ctrl_q.rate),
    .edge_stb(edge_stb), .leading(leading), .last(last), .phase(phase)
  );

  serport_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(tx_start || rx_start),
    .load_data(tx_start ? bus_wdata : '0), .edge_stb(edge_stb),
    .leading(leading), .cpha(ctrl_q.cpha), .sdi(sdi),
    .shreg(shreg), .sdo(sdo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= XF_IDLE;
      full_q <= 1'b0;
      done_q <= 1'b0;
      werr_q <= 1'b0;
      rerr_q <= 1'b0;
    end else begin
      if (ctrl_wr && !busy) begin
        ctrl_q       <= wctrl;
        ctrl_q.rx_go <= rx_start;
      end else if (finish && mode_q == XF_RX) begin
        ctrl_q.rx_go <= 1'b0;
      end

      if (tx_start)      mode_q <= XF_TX;
      else if (rx_start) mode_q <= XF_RX;
      else if (finish)   mode_q <= XF_IDLE;

      if (finish && mode_q == XF_RX)        full_q <= 1'b1;
      else if (tx_start || (data_rd && !busy)) full_q <= 1'b0;

      if (finish)                        done_q <= 1'b1;
      else if (stat_wr && bus_wdata[0])  done_q <= 1'b0;

      if (blocked && mode_q == XF_TX)    werr_q <= 1'b1;
      else if (stat_wr && bus_wdata[1])  werr_q <= 1'b0;

      if (blocked && mode_q == XF_RX)    rerr_q <= 1'b1;
      else if (stat_wr && bus_wdata[2])  rerr_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_sel)
      REG_CTRL: bus_rdata = DATA_W'(ctrl_q);
      REG_DATA: bus_rdata = busy ? '0 : shreg;
      REG_STAT: bus_rdata = DATA_W'({rerr_q, werr_q, done_q});
      default:  bus_rdata = '0;
    endcase
  end

  assign irq  = done_q;
  assign sclk = phase ^ ctrl_q.cpol;

  // R6: receive-go reads 1 exactly while a receive runs
  p_rxgo_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XF_RX) == ctrl_q.rx_go);
  // R7: completion raises the interrupt on the next cycle
  p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> irq);
  // R8: a blocked access leaves the transfer direction alone
  p_block_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !finish) |=> (mode_q == $past(mode_q)));
  // R8: a blocked control write leaves the mode fields unchanged
  p_block_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ($stable(ctrl_q.en) && $stable(ctrl_q.cpol) &&
                 $stable(ctrl_q.cpha) && $stable(ctrl_q.rate)));
  // R10: a write error survives until its own clear bit is written
  p_werr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (werr_q && !(stat_wr && bus_wdata[1])) |=> werr_q);
  // R10: a read error survives until its own clear bit is written
  p_rerr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rerr_q && !(stat_wr && bus_wdata[2])) |=> rerr_q);
endmodule

// File: tb/tb_serport_master.sv
module tb_serport_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq, sclk, sdo;
  logic sdi = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int tick_mode = 1;   // 0 none, 1 every cycle, 2 random
  bit finished = 0;

  // slave model state
  int arm_seq = 0, seen_seq = 0;
  logic [7:0] arm_byte = 8'h00;
  logic arm_cpha = 1'b0;
  logic [7:0] s_sh = 8'h00, s_rx = 8'h00;
  logic s_cpha = 1'b0, s_prev = 1'b0;
  int s_ecnt = 0, s_gap = 0, s_since = 0;

  serport_master dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (tick_mode == 0)      mc_tick <= 1'b0;
    else if (tick_mode == 1) mc_tick <= 1'b1;
    else                     mc_tick <= (($urandom % 4) != 0);
  end

  always @(negedge clk) begin
    if (arm_seq != seen_seq) begin
      seen_seq = arm_seq;
      s_cpha = arm_cpha;
      s_rx = 8'h00; s_ecnt = 0; s_gap = 0; s_since = 0;
      s_prev = sclk;
      if (!arm_cpha) begin sdi = arm_byte[7]; s_sh = arm_byte << 1; end
      else begin sdi = 1'b0; s_sh = arm_byte; end
    end else if (sclk !== s_prev) begin
      s_prev = sclk;
      s_ecnt++;
      if (s_ecnt == 2) s_gap = s_since;
      s_since = 1;
      if ((s_ecnt % 2 == 1) ^ s_cpha) s_rx = {s_rx[6:0], sdo};
      else begin sdi = s_sh[7]; s_sh = s_sh << 1; end
    end else begin
      s_since++;
    end
  end

  function automatic logic [7:0] ctrl_byte(input logic en, cpol, cpha,
                                           input logic [1:0] rate, input logic go);
    return {2'b00, go, rate, cpha, cpol, en};
  endfunction

  function automatic int half_exp(input logic [1:0] rate);
    return (4 << rate) / 2;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic arm(input logic [7:0] b, input logic cpha);
    arm_byte = b; arm_cpha = cpha; arm_seq++;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    bit ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
    chk(req, "completion irq", 32'(ok), 32'd1);
    @(negedge clk);
  endtask

  task automatic xfer(input bit is_rx, input logic cpol, cpha,
                      input logic [1:0] rate, input logic [7:0] mb, sb,
                      input int tmode);
    logic [7:0] v;
    string rq;
    rq = cpha ? "R3" : "R2";
    tick_mode = tmode;
    wr(2'd0, ctrl_byte(1, cpol, cpha, rate, 0));
    arm(is_rx ? sb : sb, cpha);
    if (!is_rx) wr(2'd1, mb);
    else        wr(2'd0, ctrl_byte(1, cpol, cpha, rate, 1));
    wait_irq("R7");
    chk("R2", "sclk toggle count", 32'(s_ecnt), 32'd16);
    chk("R2", "sclk idle level", 32'(sclk), 32'(cpol));
    if (tmode == 1) chk("R4", "half period", 32'(s_gap), 32'(half_exp(rate)));
    if (!is_rx) chk(rq, "byte seen by slave", 32'(s_rx), 32'(mb));
    else begin
      rd(2'd0, v); chk("R6", "rx_go cleared", 32'(v[5]), 32'd0);
      rd(2'd1, v); chk(is_rx && cpha ? "R3" : "R6", "received byte", 32'(v), 32'(sb));
    end
    rd(2'd2, v); chk("R7", "status after done", 32'(v), 32'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R7", "status after clear", 32'(v), 32'h00);
    chk("R7", "irq after clear", 32'(irq), 32'd0);
  endtask

  initial begin
    #(1500000 * 1ns);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0019));
    idle(5);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, v); chk("R1", "ctrl", 32'(v), 32'h00);
    rd(2'd2, v); chk("R1", "status", 32'(v), 32'h00);
    rd(2'd1, v); chk("R1", "data", 32'(v), 32'h00);
    chk("R1", "sclk", 32'(sclk), 32'd0);
    chk("R1", "sdo", 32'(sdo), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);

    // directed modes
    xfer(0, 0, 0, 0, 8'hA5, 8'h00, 1);
    xfer(0, 1, 1, 1, 8'h3C, 8'h00, 1);
    xfer(1, 0, 1, 2, 8'h00, 8'h96, 1);
    xfer(1, 1, 0, 3, 8'h00, 8'h81, 1);

    // R4 no ticks, no progress
    tick_mode = 0;
    wr(2'd0, ctrl_byte(1, 0, 0, 0, 0));
    arm(8'h00, 0);
    wr(2'd1, 8'h5A);
    idle(60);
    chk("R4", "toggles without tick", 32'(s_ecnt), 32'd0);
    tick_mode = 1;
    wait_irq("R4");
    chk("R4", "byte after ticks resume", 32'(s_rx), 32'h5A);
    wr(2'd2, 8'h01);

    // R8 blocked accesses during send
    wr(2'd0, ctrl_byte(1, 0, 0, 3, 0));
    arm(8'h00, 0);
    wr(2'd1, 8'hC3);
    idle(30);
    wr(2'd1, 8'h0F);
    wr(2'd0, ctrl_byte(1, 1, 1, 0, 0));
    rd(2'd1, v);
    rd(2'd2, v); chk("R8", "write error during send", 32'(v), 32'h02);
    chk("R10", "irq not raised by error", 32'(irq), 32'd0);
    rd(2'd0, v); chk("R8", "ctrl unchanged", 32'(v), 32'(ctrl_byte(1, 0, 0, 3, 0)));
    wait_irq("R8");
    chk("R8", "byte intact on line", 32'(s_rx), 32'hC3);
    rd(2'd2, v); chk("R8", "status at end", 32'(v), 32'h03);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R10", "error kept after done clear", 32'(v), 32'h02);
    wr(2'd2, 8'h02);
    rd(2'd2, v); chk("R10", "error cleared", 32'(v), 32'h00);

    // R9 blocked accesses during receive
    arm(8'h6E, 1);
    wr(2'd0, ctrl_byte(1, 0, 1, 3, 1));
    idle(30);
    rd(2'd1, v);
    wr(2'd0, ctrl_byte(1, 0, 0, 0, 0));
    rd(2'd2, v); chk("R9", "read error during receive", 32'(v), 32'h04);
    wait_irq("R9");
    rd(2'd2, v); chk("R9", "status at end", 32'(v), 32'h05);
    wr(2'd2, 8'h05);

    // R5 receive refused while byte unread
    arm(8'h11, 1);
    wr(2'd0, ctrl_byte(1, 0, 1, 0, 1));
    rd(2'd0, v); chk("R5", "rx_go refused", 32'(v[5]), 32'd0);
    idle(80);
    chk("R5", "no clock when held", 32'(s_ecnt), 32'd0);
    rd(2'd2, v); chk("R5", "no done when held", 32'(v), 32'h00);
    rd(2'd1, v); chk("R9", "received byte intact", 32'(v), 32'h6E);
    xfer(1, 0, 1, 0, 8'h00, 8'h11, 1);

    // R11 disabled port
    wr(2'd0, 8'h00);
    arm(8'h00, 0);
    wr(2'd1, 8'h77);
    wr(2'd0, ctrl_byte(0, 0, 0, 0, 1));
    idle(80);
    chk("R11", "no clock when disabled", 32'(s_ecnt), 32'd0);
    rd(2'd0, v); chk("R11", "ctrl when disabled", 32'(v), 32'h00);
    rd(2'd2, v); chk("R11", "no done when disabled", 32'(v), 32'h00);

    // random mix
    for (int i = 0; i < 24; i++) begin
      xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
           2'($urandom % 4), 8'($urandom), 8'($urandom), 1 + int'($urandom % 2));
    end

    summary();
  end
endmodule